// File: doc/BRIEF.md
# Dual-Output Compare Waveform Timer

This block is a timer channel that runs only in waveform mode. One up-counter feeds two pulse outputs, A and B. The counter advances on ticks from a selectable source: the core clock divided by 2, 8, 32 or 128, an external slow tick (a one-cycle pulse at roughly 32 kHz, already synchronised to `clk`), or an optional generic tick. When the count equals the period compare value C, the counter returns to zero, so C sets the period that both outputs share. Each output has its own compare value, which acts on that output alone.

Each output reacts to three events: its own compare match, the period match and a software trigger. For each event a 2-bit action field chooses none, set or clear. Software reaches the block through plain single-cycle register writes. These load the mode word and the three compare values, or issue a command that starts or stops the tick source and can fire the software trigger. The trigger applies each output's trigger action and restarts the counter and the prescaler from zero. Software therefore applies a new configuration with a trigger, and it produces a constant level by leaving both compare actions at none.

Top module: `wave_timer`

## Requirements
- R1: After reset both outputs are low and the clock is off. Until a command enables the clock, the outputs do not change, whatever mode or compare values are written.
- R2: Mode bits [2:0] select the tick source: 0 = clk/2, 1 = clk/8, 2 = clk/32, 3 = clk/128, 4 = one tick per cycle with `slow_tick` high, 5 = one tick per cycle with `gen_tick` high only when GEN_CLK_EN is 1 (otherwise no ticks), 6 and 7 = no ticks. The counter makes one step per tick.
- R3: On a tick the counter counts up from 0. On the tick where it equals compare C it returns to 0, which gives a period of (C+1) ticks.
- R4: The action encoding is 00 none, 01 set, 10 clear, 11 none. Output A uses mode bits [4:3] (own compare), [6:5] (period compare) and [8:7] (trigger). Output B uses bits [10:9], [12:11] and [14:13] in the same roles.
- R5: Compare value A and the actions of A change only `out_a`. Compare value B and the actions of B change only `out_b`.
- R6: Normal polarity uses own = clear, period = set, trigger = set. After a trigger with the clock enabled at divide d, `out_a` is high for d*(A+1) cycles out of every d*(C+1) cycles, starting high on the cycle after the command.
- R7: Inverted polarity uses own = set, period = clear, trigger = clear. This gives the complementary waveform: low for d*(B+1) cycles, then high for the rest of the period.
- R8: When the own compare and the period compare match on the same tick, only the period action is applied.
- R9: Register addresses: 0 mode, 1 compare A, 2 compare B, 3 compare C, 4 command. Command bits: bit 0 enables the clock, bit 1 disables it (and wins over bit 0), bit 2 fires the software trigger. The trigger takes effect on the write edge, ahead of any compare action, and zeroes the counter and the prescaler.
- R10: While the clock is off, the counter and both outputs hold their values. A trigger still applies its actions. A later enable resumes counting from zero.
- R11: When both compare actions of an output are none, the output keeps the level set by the last trigger for any number of periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| slow_tick | input | 1 | Slow tick pulse, synchronous to clk |
| gen_tick | input | 1 | Generic tick pulse, synchronous to clk |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |

## Verification
The case hardest to reach from the ports is an own compare and the period compare landing on the same tick. Otherwise the two actions apply on separate ticks and a wrong priority leaves no trace. The bench sets compare A equal to compare C, with own = set and period = clear. An output that ever goes high then shows that the wrong action won. A second hard case is a trigger issued while the clock is off. The bench disables the clock, fires a trigger with a changed trigger action, and then enables the clock without a trigger. The resulting waveform must start from a zeroed counter with the new level.

// File: rtl/wt_pkg.sv
package wt_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_RSVD = 2'b11
  } act_e;

  // Per-output action fields, packed LSB first as: own, period, trigger
  typedef struct packed {
    act_e on_trig;
    act_e on_period;
    act_e on_own;
  } out_cfg_t;

  localparam int SEL_W   = 3;
  localparam int ADDR_W  = 3;
  localparam int NUM_OUT = 2;
  localparam int CFG_W   = $bits(out_cfg_t);
  localparam int MODE_W  = SEL_W + NUM_OUT * CFG_W;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPC = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CMD  = 3'd4;

  localparam int CMD_EN_BIT   = 0;
  localparam int CMD_DIS_BIT  = 1;
  localparam int CMD_TRIG_BIT = 2;

  function automatic logic act_apply(input act_e act, input logic cur);
    logic res;
    case (act)
      ACT_SET: res = 1'b1;
      ACT_CLR: res = 1'b0;
      default: res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/wt_regs.sv
module wt_regs
  import wt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [SEL_W-1:0]  sel,
  output out_cfg_t          cfg     [NUM_OUT],
  output logic [CNT_W-1:0]  cmp_own [NUM_OUT],
  output logic [CNT_W-1:0]  cmp_per,
  output logic              clk_on,
  output logic              trig
);

  logic [MODE_W-1:0] mode_q, mode_d;
  logic [CNT_W-1:0]  per_q, per_d;
  logic              on_q, on_d;
  logic              is_cmd;

  assign is_cmd = wr_en && (wr_addr == ADDR_CMD);
  assign trig   = is_cmd && wr_data[CMD_TRIG_BIT];

  always_comb begin
    mode_d = mode_q;
    per_d  = per_q;
    on_d   = on_q;
    if (wr_en && wr_addr == ADDR_MODE) mode_d = wr_data[MODE_W-1:0];
    if (wr_en && wr_addr == ADDR_CMPC) per_d = wr_data;
    if (is_cmd) begin
      if (wr_data[CMD_DIS_BIT])     on_d = 1'b0;
      else if (wr_data[CMD_EN_BIT]) on_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      per_q  <= '0;
      on_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      per_q  <= per_d;
      on_q   <= on_d;
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_own
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_CMPA + ADDR_W'(i);
    logic [CNT_W-1:0] own_q, own_d;

    always_comb begin
      own_d = own_q;
      if (wr_en && wr_addr == MY_ADDR) own_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) own_q <= '0;
      else        own_q <= own_d;
    end

    assign cmp_own[i] = own_q;
    assign cfg[i]     = out_cfg_t'(mode_q[SEL_W + CFG_W*i +: CFG_W]);
  end

  assign sel     = mode_q[SEL_W-1:0];
  assign cmp_per = per_q;
  assign clk_on  = on_q;

  // R9
  dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && wr_data[CMD_DIS_BIT]) |=> !clk_on);

endmodule

// File: rtl/wt_prescaler.sv
module wt_prescaler
  import wt_pkg::*;
#(
  parameter int NUM_DIV    = 4,
  parameter bit GEN_CLK_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_on,
  input  logic             trig,
  input  logic [SEL_W-1:0] sel,
  input  logic             slow_tick,
  input  logic             gen_tick,
  output logic             tick
);

  // Divider i ticks once every 2^(2i+1) cycles
  localparam int PRE_W = 2*NUM_DIV - 1;
  localparam logic [SEL_W-1:0] SEL_SLOW = SEL_W'(NUM_DIV);
  localparam logic [SEL_W-1:0] SEL_GEN  = SEL_W'(NUM_DIV + 1);

  logic [PRE_W-1:0]   pre_q, pre_d;
  logic [NUM_DIV-1:0] dtick;
  logic               src;

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    localparam int SH = 2*i + 1;
    assign dtick[i] = &pre_q[SH-1:0];
  end

  always_comb begin
    src = 1'b0;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (sel == SEL_W'(i)) src = dtick[i];
    end
    if (sel == SEL_SLOW) src = slow_tick;
    if (sel == SEL_GEN)  src = GEN_CLK_EN && gen_tick;
  end

  assign tick = clk_on && src;

  always_comb begin
    pre_d = pre_q;
    if (trig)        pre_d = '0;
    else if (clk_on) pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R2
  div2_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel == '0) |=> !(tick && sel == '0));

endmodule

// File: rtl/wt_counter.sv
module wt_counter
  import wt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trig,
  input  logic [CNT_W-1:0] cmp_per,
  input  logic [CNT_W-1:0] cmp_own [NUM_OUT],
  output logic [CNT_W-1:0] cnt,
  output logic             hit_per,
  output logic [NUM_OUT-1:0] hit_own
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end  = (cnt_q == cmp_per);
  assign hit_per = tick && at_end;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_hit
    assign hit_own[i] = tick && (cnt_q == cmp_own[i]);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (trig)        cnt_d = '0;
    else if (tick) begin
      if (at_end)    cnt_d = '0;
      else           cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !trig && cnt == cmp_per) |=> cnt == '0);

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !trig && cnt != cmp_per) |=> cnt == $past(cnt) + CNT_W'(1));

  // R9
  trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> cnt == '0);

endmodule

// File: rtl/wt_out_unit.sv
module wt_out_unit
  import wt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     trig,
  input  logic     hit_own,
  input  logic     hit_per,
  input  out_cfg_t cfg,
  output logic     lvl
);

  logic lvl_q, lvl_d;

  // Priority: trigger, then period match, then own match
  always_comb begin
    lvl_d = lvl_q;
    if (trig)         lvl_d = act_apply(cfg.on_trig, lvl_q);
    else if (hit_per) lvl_d = act_apply(cfg.on_period, lvl_q);
    else if (hit_own) lvl_d = act_apply(cfg.on_own, lvl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign lvl = lvl_q;

  // R8
  per_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && hit_per && hit_own && cfg.on_period == ACT_CLR) |=> !lvl);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !hit_per && !hit_own) |=> $stable(lvl));

  // R9
  trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && cfg.on_trig == ACT_SET) |=> lvl);

endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wt_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter bit GEN_CLK_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             slow_tick,
  input  logic             gen_tick,
  output logic             out_a,
  output logic             out_b
);

  localparam int NUM_DIV = 4;

  logic [1:0]         rs_q;
  logic               core_rst_n;
  logic [SEL_W-1:0]   sel;
  out_cfg_t           cfg     [NUM_OUT];
  logic [CNT_W-1:0]   cmp_own [NUM_OUT];
  logic [CNT_W-1:0]   cmp_per;
  logic               clk_on;
  logic               trig;
  logic               tick;
  logic [CNT_W-1:0]   cnt;
  logic               hit_per;
  logic [NUM_OUT-1:0] hit_own;
  logic [NUM_OUT-1:0] lvl;

  // Reset asserts at once, deasserts two clock edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  wt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sel     (sel),
    .cfg     (cfg),
    .cmp_own (cmp_own),
    .cmp_per (cmp_per),
    .clk_on  (clk_on),
    .trig    (trig)
  );

  wt_prescaler #(.NUM_DIV(NUM_DIV), .GEN_CLK_EN(GEN_CLK_EN)) u_pre (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .clk_on    (clk_on),
    .trig      (trig),
    .sel       (sel),
    .slow_tick (slow_tick),
    .gen_tick  (gen_tick),
    .tick      (tick)
  );

  wt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .tick    (tick),
    .trig    (trig),
    .cmp_per (cmp_per),
    .cmp_own (cmp_own),
    .cnt     (cnt),
    .hit_per (hit_per),
    .hit_own (hit_own)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    wt_out_unit u_out (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .trig    (trig),
      .hit_own (hit_own[i]),
      .hit_per (hit_per),
      .cfg     (cfg[i]),
      .lvl     (lvl[i])
    );
  end

  assign out_a = lvl[0];
  assign out_b = lvl[1];

  // R10
  off_cnt_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!clk_on && !trig) |=> $stable(cnt));

  // R10
  off_out_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!clk_on && !trig) |=> ($stable(out_a) && $stable(out_b)));

  // R1
  rst_low_chk: assert property (@(posedge clk)
    !core_rst_n |-> (!out_a && !out_b));

endmodule

// File: tb/tb_wave_timer.sv
module tb_wave_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        slow_tick = 1'b0;
  logic        gen_tick = 1'b0;
  logic        out_a, out_b;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wave_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .slow_tick(slow_tick), .gen_tick(gen_tick),
    .out_a(out_a), .out_b(out_b)
  );

  localparam logic [1:0] NO = 2'b00, ST = 2'b01, CL = 2'b10, RS = 2'b11;

  function automatic logic [15:0] mk(input logic [2:0] sel,
      input logic [1:0] ao, input logic [1:0] ap, input logic [1:0] at,
      input logic [1:0] bo, input logic [1:0] bp, input logic [1:0] bt);
    return {1'b0, bt, bp, bo, at, ap, ao, sel};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One write; returns at the negedge just after the write edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [15:0] mode, input int ca, input int cb, input int cc);
    wr(3'd0, mode);
    wr(3'd1, 16'(ca));
    wr(3'd2, 16'(cb));
    wr(3'd3, 16'(cc));
  endtask

  // Expected output t cycles after the trigger edge
  task automatic wave_check(input string req, input int div, input int cmp, input int per,
                            input bit inv, input bit on_b, input int n, input bit other_hold);
    logic other = on_b ? out_a : out_b;
    for (int t = 0; t < n; t++) begin
      int phase = t % (div * (per + 1));
      logic e = (phase < div * (cmp + 1)) ^ inv;
      logic a = on_b ? out_b : out_a;
      chk(a == e, req, a, e);
      if (other_hold) chk((on_b ? out_a : out_b) == other, "R5 other output held",
                          on_b ? out_a : out_b, other);
      @(negedge clk);
    end
  endtask

  task automatic hold_check(input string req, input bit on_b, input logic lvl, input int n);
    for (int t = 0; t < n; t++) begin
      logic a = on_b ? out_b : out_a;
      chk(a == lvl, req, a, lvl);
      @(negedge clk);
    end
  endtask

  task automatic test_reset();
    chk(out_a == 1'b0, "R1 reset out_a", out_a, 0);
    chk(out_b == 1'b0, "R1 reset out_b", out_b, 0);
    setup(mk(3'd0, CL, ST, ST, CL, ST, ST), 1, 1, 3);
    hold_check("R1 idle out_a", 1'b0, 1'b0, 30);
    hold_check("R1 idle out_b", 1'b1, 1'b0, 5);
  endtask

  task automatic test_normal_a();
    setup(mk(3'd0, CL, ST, ST, NO, NO, NO), 3, 2, 9);
    wr(3'd4, 16'h5);
    wave_check("R6 normal A div2", 2, 3, 9, 1'b0, 1'b0, 60, 1'b1);
  endtask

  task automatic test_divs();
    setup(mk(3'd1, CL, ST, ST, NO, NO, NO), 1, 0, 3);
    wr(3'd4, 16'h5);
    wave_check("R2 R3 div8", 8, 1, 3, 1'b0, 1'b0, 100, 1'b0);
    setup(mk(3'd2, CL, ST, ST, NO, NO, NO), 2, 0, 4);
    wr(3'd4, 16'h5);
    wave_check("R2 R3 div32", 32, 2, 4, 1'b0, 1'b0, 340, 1'b0);
    setup(mk(3'd3, CL, ST, ST, NO, NO, NO), 0, 0, 2);
    wr(3'd4, 16'h5);
    wave_check("R2 R3 div128", 128, 0, 2, 1'b0, 1'b0, 800, 1'b0);
  endtask

  task automatic test_inverted_b();
    setup(mk(3'd1, NO, NO, NO, ST, CL, CL), 0, 1, 3);
    wr(3'd4, 16'h5);
    wave_check("R7 inverted B div8", 8, 1, 3, 1'b1, 1'b1, 100, 1'b1);
  endtask

  task automatic test_coincide();
    setup(mk(3'd0, ST, CL, CL, NO, NO, NO), 4, 0, 4);
    wr(3'd4, 16'h5);
    hold_check("R8 period action wins", 1'b0, 1'b0, 60);
    setup(mk(3'd0, ST, CL, CL, NO, NO, NO), 0, 0, 0);
    wr(3'd4, 16'h5);
    hold_check("R8 period wins at zero", 1'b0, 1'b0, 30);
  endtask

  task automatic test_hold_level();
    setup(mk(3'd0, RS, NO, ST, NO, NO, NO), 2, 0, 5);
    wr(3'd4, 16'h5);
    hold_check("R11 R4 hold high", 1'b0, 1'b1, 60);
    wr(3'd0, mk(3'd0, RS, NO, CL, NO, NO, NO));
    wr(3'd4, 16'h4);
    hold_check("R11 R4 hold low", 1'b0, 1'b0, 60);
  endtask

  task automatic test_disable();
    logic h;
    setup(mk(3'd0, CL, ST, ST, NO, NO, NO), 3, 0, 9);
    wr(3'd4, 16'h5);
    repeat (3) @(negedge clk);
    wr(3'd4, 16'h2);
    h = out_a;
    chk(h == 1'b1, "R10 level before stop", h, 1);
    hold_check("R10 hold while off", 1'b0, h, 40);
    wr(3'd0, mk(3'd0, CL, ST, CL, NO, NO, NO));
    wr(3'd4, 16'h6);
    hold_check("R10 trigger while off", 1'b0, 1'b0, 30);
    wr(3'd4, 16'h1);
    for (int t = 0; t < 70; t++) begin
      logic e = (t < 20) ? 1'b0 : (((t - 20) % 20) < 8);
      chk(out_a == e, "R10 R9 resume from zero", out_a, e);
      @(negedge clk);
    end
  endtask

  task automatic test_both_cmd();
    setup(mk(3'd0, CL, ST, ST, NO, NO, NO), 1, 0, 3);
    wr(3'd4, 16'h7);
    hold_check("R9 disable wins over enable", 1'b0, 1'b1, 60);
  endtask

  task automatic pulse_slow();
    @(negedge clk);
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
  endtask

  task automatic test_slow();
    setup(mk(3'd4, CL, ST, ST, NO, NO, NO), 1, 0, 2);
    wr(3'd4, 16'h5);
    hold_check("R2 slow no pulse", 1'b0, 1'b1, 20);
    pulse_slow();
    chk(out_a == 1'b1, "R2 slow tick 1", out_a, 1);
    repeat (6) @(negedge clk);
    chk(out_a == 1'b1, "R2 slow between ticks", out_a, 1);
    pulse_slow();
    chk(out_a == 1'b0, "R2 slow tick 2", out_a, 0);
    repeat (6) @(negedge clk);
    pulse_slow();
    chk(out_a == 1'b1, "R2 slow tick 3", out_a, 1);
  endtask

  task automatic test_gen_off();
    gen_tick = 1'b1;
    setup(mk(3'd5, CL, ST, ST, NO, NO, NO), 0, 0, 1);
    wr(3'd4, 16'h5);
    hold_check("R2 generic tick absent", 1'b0, 1'b1, 50);
    gen_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_normal_a();
    test_divs();
    test_inverted_b();
    test_coincide();
    test_hold_level();
    test_disable();
    test_both_cmd();
    test_slow();
    test_gen_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule